// File: doc/BRIEF.md
# Two-Read One-Write Register File with Null Index

This block holds the eight 32-bit general-purpose registers of a small processor datapath. It has two read ports for the two source operands and one write port for the result. Each port is addressed by a 4-bit register index. Reads are combinational: a read port's data output follows its index input within the same cycle, and no clock is involved. The write port stores its data into the addressed entry on the rising clock edge.

Index 8 is reserved to mean "no register". The decode stage uses it to switch off an access without a separate enable line. A read of index 8, or of any index above 7, returns zero. A write to any such index changes nothing. The datapath drives all three ports in every cycle. A read of the entry that is being written in the same cycle returns the old contents until the edge, because the block does no forwarding. A synchronous reset clears every entry.

Top module: `rf_dual_read`

## Requirements
- R1: The block holds eight 32-bit entries at indices 0 to 7. Each entry keeps its own value, and writing one entry leaves the other seven unchanged. Index 4 holds the stack pointer.
- R2: Each read port's data output equals the contents of the entry at that port's index, in the same cycle as the index is applied, with no clock edge needed.
- R3: A read of index 8 (the null index), or of any index from 9 to 15, returns 0.
- R4: When reset is low and the write index is 0 to 7, the write data is stored in that entry at the rising clock edge. Reads see the new value from that edge onward.
- R5: A write to index 8 through 15 is ignored, and all eight entries keep their values.
- R6: A read of the entry being written returns the old value until the clock edge. The block does no write-to-read forwarding.
- R7: When `rst` is high at a rising edge, all eight entries become 0. Reset takes priority over a write in the same cycle.
- R8: Both read ports and the write port work independently in the same cycle. The two read ports may address the same entry or different entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_id | input | 4 | Index of read port A (8 to 15 = no register) |
| rd_a_data | output | 32 | Data of read port A |
| rd_b_id | input | 4 | Index of read port B (8 to 15 = no register) |
| rd_b_data | output | 32 | Data of read port B |
| wr_id | input | 4 | Index of the write port (8 to 15 = no write) |
| wr_data | input | 32 | Data of the write port |

## Verification
The bench builds the block with its default parameters: eight entries of 32 bits and 4-bit indices. With these values the index space has eight unused codes above the register range, so null reads and suppressed writes can be driven with index 8, with index 15 and with the codes between them. The full index range is small enough for a pseudo-random phase to hit same-cycle read-of-written collisions and reset-over-write cycles often. Every read result is compared with a behavioural model.

// File: rtl/rf_pkg.sv
package rf_pkg;
    parameter int RF_DATA_W  = 32;
    parameter int RF_ID_W    = 4;
    parameter int RF_NUM_REG = 8;

    // Index assignment of the general registers
    typedef enum logic [3:0] {
        GR_ACC  = 4'd0,
        GR_CNT  = 4'd1,
        GR_DAT  = 4'd2,
        GR_BAS  = 4'd3,
        GR_STK  = 4'd4,
        GR_FRM  = 4'd5,
        GR_SRC  = 4'd6,
        GR_DST  = 4'd7,
        GR_NONE = 4'd8
    } gr_id_e;
endpackage

// File: rtl/rf_id_decode.sv
module rf_id_decode #(
    parameter int ID_W    = rf_pkg::RF_ID_W,
    parameter int NUM_REG = rf_pkg::RF_NUM_REG,
    localparam int IDX_W  = $clog2(NUM_REG)
) (
    input  logic [ID_W-1:0]  id,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = (int'(id) < NUM_REG);
        idx = id[IDX_W-1:0];
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int DATA_W  = rf_pkg::RF_DATA_W,
    parameter int ID_W    = rf_pkg::RF_ID_W,
    parameter int NUM_REG = rf_pkg::RF_NUM_REG,
    localparam int IDX_W  = $clog2(NUM_REG)
) (
    input  logic [NUM_REG-1:0][DATA_W-1:0] regs,
    input  logic [ID_W-1:0]                id,
    output logic [DATA_W-1:0]              data
);
    logic             hit;
    logic [IDX_W-1:0] idx;

    rf_id_decode #(.ID_W(ID_W), .NUM_REG(NUM_REG)) u_dec (
        .id  (id),
        .hit (hit),
        .idx (idx)
    );

    always_comb begin
        data = hit ? regs[idx] : '0;
    end
endmodule

// File: rtl/rf_dual_read.sv
module rf_dual_read #(
    parameter int DATA_W  = rf_pkg::RF_DATA_W,
    parameter int ID_W    = rf_pkg::RF_ID_W,
    parameter int NUM_REG = rf_pkg::RF_NUM_REG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   rd_a_id,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int IDX_W   = $clog2(NUM_REG);
    localparam int NUM_RDP = 2;

    typedef struct packed {
        logic [NUM_REG-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic             wr_hit;
    logic [IDX_W-1:0] wr_idx;

    rf_id_decode #(.ID_W(ID_W), .NUM_REG(NUM_REG)) u_wdec (
        .id  (wr_id),
        .hit (wr_hit),
        .idx (wr_idx)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.regs = '0;
        end else if (wr_hit) begin
            st_d.regs[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    logic [NUM_RDP-1:0][ID_W-1:0]   rd_id;
    logic [NUM_RDP-1:0][DATA_W-1:0] rd_data;

    assign rd_id[0]  = rd_a_id;
    assign rd_id[1]  = rd_b_id;
    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];

    for (genvar p = 0; p < NUM_RDP; p++) begin : g_rdp
        rf_read_port #(.DATA_W(DATA_W), .ID_W(ID_W), .NUM_REG(NUM_REG)) u_rp (
            .regs (st_q.regs),
            .id   (rd_id[p]),
            .data (rd_data[p])
        );
    end

    // R3
    null_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_a_id) >= NUM_REG) |-> (rd_a_data == '0 && (int'(rd_b_id) < NUM_REG || rd_b_data == '0)));

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(wr_id) < NUM_REG) |=> (st_q.regs[$past(wr_id[IDX_W-1:0])] == $past(wr_data)));

    // R5
    null_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(wr_id) >= NUM_REG) |=> $stable(st_q.regs));

    // R7
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (st_q.regs == '0));

    // R6
    no_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(wr_id) < NUM_REG && rd_a_id == wr_id) |-> (rd_a_data == st_q.regs[wr_id[IDX_W-1:0]]));
endmodule

// File: tb/sim_rf_dual_read.sv
module sim_rf_dual_read;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_id = 4'd0;
    logic [3:0]  rd_b_id = 4'd0;
    logic [3:0]  wr_id = 4'd8;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_a_data, rd_b_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] model [8];

    always #5 clk = ~clk;

    rf_dual_read u0 (
        .clk(clk), .rst(rst),
        .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
        .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
        .wr_id(wr_id), .wr_data(wr_data)
    );

    function automatic logic [31:0] ref_read(input logic [3:0] id);
        if (id < 4'd8) return model[id[2:0]];
        return 32'd0;
    endfunction

    function automatic string auto_tag(input logic [3:0] id);
        if (id >= 4'd8) return "R3";
        if (!rst && wr_id < 4'd8 && id == wr_id) return "R6";
        return "R2";
    endfunction

    task automatic cmp(input string tag, input string port, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s port %s: actual %h expected %h", tag, port, act, exp);
        end
    endtask

    // drive one cycle, check both reads mid-cycle, then advance the model at the edge
    task automatic step(input logic r, input logic [3:0] a, input logic [3:0] b,
                        input logic [3:0] w, input logic [31:0] d, input string tag);
        @(negedge clk);
        rst = r; rd_a_id = a; rd_b_id = b; wr_id = w; wr_data = d;
        #1;
        cmp(tag == "" ? auto_tag(a) : tag, "A", rd_a_data, ref_read(a));
        cmp(tag == "" ? auto_tag(b) : tag, "B", rd_b_data, ref_read(b));
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 8; i++) model[i] = 32'd0;
        end else if (w < 4'd8) begin
            model[w[2:0]] = d;
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = 32'hxxxx_xxxx;
        @(posedge clk);
        @(posedge clk);
        for (int i = 0; i < 8; i++) model[i] = 32'd0;
        // R7: reset state reads as zero
        for (int i = 0; i < 8; i += 2) step(1'b0, 4'(i), 4'(i + 1), 4'd8, 32'd0, "R7");
        // R1 / R4: fill every entry with a distinct value, read each back
        for (int i = 0; i < 8; i++) step(1'b0, 4'd8, 4'd8, 4'(i), 32'hA5000000 + 32'(i * 17), "R4");
        for (int i = 0; i < 8; i++) step(1'b0, 4'(i), 4'(7 - i), 4'd8, 32'd0, "R1");
        // R1: stack-pointer index 4 keeps its own value while its neighbour changes
        step(1'b0, 4'd8, 4'd8, 4'd3, 32'h0000_0100, "R1");
        step(1'b0, 4'(rf_pkg::GR_STK), 4'd3, 4'd8, 32'd0, "R1");
        // R5: writes to null and out-of-range indices change nothing
        step(1'b0, 4'd0, 4'd1, 4'd8,  32'hDEAD_BEEF, "R5");
        step(1'b0, 4'd2, 4'd3, 4'd15, 32'hDEAD_BEEF, "R5");
        step(1'b0, 4'd4, 4'd5, 4'd11, 32'hDEAD_BEEF, "R5");
        for (int i = 0; i < 8; i += 2) step(1'b0, 4'(i), 4'(i + 1), 4'd8, 32'd0, "R5");
        // R3: null and high indices read zero
        step(1'b0, 4'd8, 4'd15, 4'd8, 32'd0, "R3");
        step(1'b0, 4'd9, 4'd12, 4'd8, 32'd0, "R3");
        // R6: a read of the entry being written sees the old value, then the new one
        step(1'b0, 4'd5, 4'd5, 4'd5, 32'h1234_5678, "R6");
        step(1'b0, 4'd5, 4'd6, 4'd8, 32'd0, "R6");
        // R8: both reads and a write to a third entry in one cycle
        step(1'b0, 4'd1, 4'd2, 4'd7, 32'h7777_0007, "R8");
        step(1'b0, 4'd7, 4'd1, 4'd2, 32'h2222_0002, "R8");
        step(1'b0, 4'd2, 4'd7, 4'd8, 32'd0, "R8");
        // R7: reset wins over a write in the same cycle
        step(1'b1, 4'd0, 4'd6, 4'd6, 32'hFFFF_FFFF, "R7");
        step(1'b0, 4'd6, 4'd0, 4'd8, 32'd0, "R7");
        // mixed pseudo-random traffic, compared with the model every cycle
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            step((r[7:0] == 8'd0), r[11:8], r[15:12], r[19:16], $urandom, "");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule